// File: doc/BRIEF.md
# Core Clock Speed Controller

This block turns one of three clock-source ticks into the enable that paces the CPU core. The three sources are a main oscillator, a slow real-time oscillator and a PLL multiplier output. The selected source is divided by a power of two between 1 and 128. Alongside the divided enable, the block passes the undivided tick of the selected source to the peripheral timers. It also drives the power-down controls of the main oscillator and the PLL.

Software changes the speed by writing a 7-bit speed word. A write takes effect only when the running divided period ends, so the command itself completes at the old rate. A second speed word, loaded through the same write port, is switched in automatically when an interrupt service routine is entered. The speed that was in use is put back when the outermost routine returns. An illegal speed word is refused, and the refusal is recorded in a sticky error flag.

Speed word layout:
- bits [2:0]: divisor code k, which divides by 2^k.
- bits [4:3]: source. 0 is the main oscillator, 1 is the real-time oscillator, 2 is the PLL, and 3 is illegal.
- bit 5: power down the main oscillator.
- bit 6: power down the PLL.

Top module: `ccs_core_clk_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `core_en`, `tmr_tick`, `osc_pd`, `pll_pd` and `cmd_err` are 0. The setting in force is main oscillator, divide by 1, nothing powered down.
- R2: With divisor code k, `core_en` pulses for one cycle on every 2^k-th tick of the selected source. Each pulse appears one cycle after that tick.
- R3: `tmr_tick` repeats every tick of the selected source, one cycle later, and is never divided.
- R4: A normal write (`cmd_isr`=0) with source code 3 is refused. It sets `cmd_err` and leaves the speed unchanged.
- R5: Once a setting is in force, `osc_pd` equals its bit 5 and `pll_pd` equals its bit 6.
- R6: A normal write is refused, and sets `cmd_err`, if its selected source is powered down either by its own bits or by the setting in force. `cmd_err` stays 1 until reset.
- R7: An accepted setting takes effect only at the end of the running divided period. The period in progress finishes at the old divisor and source. A write in the same cycle as a period end waits for the next period end.
- R8: A write with `cmd_isr`=1 loads the interrupt speed word and has no immediate effect. It is refused, with `cmd_err` set, if its source code is 3 or if it powers down its own source.
- R9: `irq_enter` with no routine active saves the current target speed. It then schedules the interrupt speed word, which applies at the next period end. `irq_return` from the outermost routine schedules the saved speed.
- R10: Nested entries (up to 7 deep) do not overwrite the saved speed. Only the return that closes the outermost routine restores it. A return with no routine active is ignored.
- R11: An accepted normal write made while a routine is active replaces the saved speed rather than the running one.
- R12: `irq_enter` and `irq_return` in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 3 | Tick per source: [0] main oscillator, [1] real-time oscillator, [2] PLL |
| cmd_we | input | 1 | Speed word write strobe |
| cmd_isr | input | 1 | 1 targets the interrupt speed word, 0 the normal speed |
| cmd_wdata | input | 7 | Speed word |
| irq_enter | input | 1 | Interrupt routine entry strobe |
| irq_return | input | 1 | Interrupt routine return strobe |
| core_en | output | 1 | Divided core clock enable |
| tmr_tick | output | 1 | Undivided selected-source tick for timers |
| osc_pd | output | 1 | Main oscillator power-down |
| pll_pd | output | 1 | PLL power-down |
| cmd_err | output | 1 | Sticky refused-write flag |

## Verification
Several functions can fall on the same clock edge. The sharpest cases are a speed write landing on the cycle that ends the running period, and an interrupt entry arriving together with a normal write. In the first case the older pending value must apply while the new one waits a full period. In the second case the new write must become the saved speed. A long random phase provokes these collisions: it writes speed words and strobes entry and return often, while the PLL ticks every cycle, so period ends are dense. A behavioural per-clock model judges the result by comparing every output on every cycle.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int DIV_CODE_W = 3;
  localparam int SRC_N      = 3;

  localparam logic [1:0] SRC_MAIN = 2'd0;
  localparam logic [1:0] SRC_RTC  = 2'd1;
  localparam logic [1:0] SRC_PLL  = 2'd2;

  typedef struct packed {
    logic                  pll_off;
    logic                  osc_off;
    logic [1:0]            src;
    logic [DIV_CODE_W-1:0] div;
  } spd_t;

  localparam spd_t SPD_RESET = '{pll_off: 1'b0, osc_off: 1'b0, src: SRC_MAIN, div: '0};

  // A setting is legal when its source exists and is powered,
  // both by its own bits and by the reference setting.
  function automatic logic spd_ok(spd_t s, spd_t cur);
    logic ok;
    ok = (s.src != 2'd3);
    if (s.src == SRC_MAIN && (s.osc_off || cur.osc_off)) ok = 1'b0;
    if (s.src == SRC_PLL  && (s.pll_off || cur.pll_off)) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/ccs_divider.sv
module ccs_divider
  import ccs_pkg::*;
#(
  parameter int DCW = DIV_CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src_tick,
  input  spd_t             act,
  output logic             bnd,
  output logic             core_en,
  output logic             tmr_tick
);
  localparam int CNT_W = (1 << DCW) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             sel;

  always_comb begin
    unique case (act.src)
      SRC_MAIN: sel = src_tick[0];
      SRC_RTC:  sel = src_tick[1];
      SRC_PLL:  sel = src_tick[2];
      default:  sel = 1'b0;
    endcase
    // 2^k - 1 in CNT_W bits; k = max wraps to all ones
    lim = (CNT_W'(1) << act.div) - CNT_W'(1);
    bnd = sel && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      core_en  <= 1'b0;
      tmr_tick <= 1'b0;
    end else begin
      core_en  <= bnd;
      tmr_tick <= sel;
      if (bnd)      cnt <= '0;
      else if (sel) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ccs_nest.sv
module ccs_nest #(
  parameter int NEST_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_enter,
  input  logic irq_return,
  output logic outer_enter,
  output logic outer_return,
  output logic in_isr
);
  localparam logic [NEST_W-1:0] NEST_MAX = '1;

  logic [NEST_W-1:0] depth;
  logic              ent, ret;

  always_comb begin
    ent          = irq_enter && !irq_return;
    ret          = irq_return && !irq_enter;
    in_isr       = (depth != '0);
    outer_enter  = ent && (depth == '0);
    outer_return = ret && (depth == NEST_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)                          depth <= '0;
    else if (ent && depth != NEST_MAX) depth <= depth + NEST_W'(1);
    else if (ret && in_isr)           depth <= depth - NEST_W'(1);
  end
endmodule

// File: rtl/ccs_speed_regs.sv
module ccs_speed_regs
  import ccs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_we,
  input  logic cmd_isr,
  input  spd_t cmd,
  input  logic bnd,
  input  logic outer_enter,
  input  logic outer_return,
  input  logic in_isr,
  output spd_t act,
  output logic cmd_err
);
  spd_t isr_q, saved_q, pend_q;
  logic pv_q;
  spd_t isr_n, saved_n, pend_n, tgt;
  logic pv_n, ok_norm, ok_isr, err_set;

  always_comb begin
    ok_norm = cmd_we && !cmd_isr && spd_ok(cmd, act);
    ok_isr  = cmd_we &&  cmd_isr && spd_ok(cmd, SPD_RESET);
    err_set = cmd_we && !ok_norm && !ok_isr;
    isr_n   = ok_isr ? cmd : isr_q;
    saved_n = saved_q;
    pend_n  = pend_q;
    pv_n    = pv_q && !bnd;
    if (ok_norm) begin
      if (in_isr) saved_n = cmd;
      else begin
        pend_n = cmd;
        pv_n   = 1'b1;
      end
    end
    tgt = (ok_norm && !in_isr) ? cmd : (pv_q ? pend_q : act);
    if (outer_enter) begin
      saved_n = tgt;
      pend_n  = isr_n;
      pv_n    = 1'b1;
    end
    if (outer_return) begin
      pend_n = saved_n;
      pv_n   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= SPD_RESET;
      isr_q   <= SPD_RESET;
      saved_q <= SPD_RESET;
      pend_q  <= SPD_RESET;
      pv_q    <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      if (bnd && pv_q) act <= pend_q;
      isr_q   <= isr_n;
      saved_q <= saved_n;
      pend_q  <= pend_n;
      pv_q    <= pv_n;
      if (err_set) cmd_err <= 1'b1;
    end
  end
endmodule

// File: rtl/ccs_core_clk_ctrl.sv
module ccs_core_clk_ctrl
  import ccs_pkg::*;
#(
  parameter int NEST_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             cmd_we,
  input  logic             cmd_isr,
  input  logic [6:0]       cmd_wdata,
  input  logic             irq_enter,
  input  logic             irq_return,
  output logic             core_en,
  output logic             tmr_tick,
  output logic             osc_pd,
  output logic             pll_pd,
  output logic             cmd_err
);
  spd_t act;
  logic bnd, outer_enter, outer_return, in_isr;

  ccs_nest #(.NEST_W(NEST_W)) u_nest (
    .clk(clk), .rst(rst), .irq_enter(irq_enter), .irq_return(irq_return),
    .outer_enter(outer_enter), .outer_return(outer_return), .in_isr(in_isr)
  );

  ccs_speed_regs u_regs (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_isr(cmd_isr),
    .cmd(spd_t'(cmd_wdata)), .bnd(bnd), .outer_enter(outer_enter),
    .outer_return(outer_return), .in_isr(in_isr), .act(act), .cmd_err(cmd_err)
  );

  ccs_divider #(.DCW(DIV_CODE_W)) u_div (
    .clk(clk), .rst(rst), .src_tick(src_tick), .act(act),
    .bnd(bnd), .core_en(core_en), .tmr_tick(tmr_tick)
  );

  assign osc_pd = act.osc_off;
  assign pll_pd = act.pll_off;
endmodule

// File: rtl/ccs_chk.sv
module ccs_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_we,
  input logic       cmd_isr,
  input logic [6:0] cmd_wdata,
  input logic       core_en,
  input logic       tmr_tick,
  input logic       osc_pd,
  input logic       pll_pd,
  input logic       cmd_err
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!core_en && !tmr_tick && !osc_pd && !pll_pd && !cmd_err));

  // R2
  core_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    core_en |-> tmr_tick);

  // R4
  bad_src_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !cmd_isr && cmd_wdata[4:3] == 2'd3) |=> cmd_err);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err);

  // R7
  osc_pd_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(osc_pd) |-> core_en);

  // R7
  pll_pd_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pll_pd) |-> core_en);
endmodule

bind ccs_core_clk_ctrl ccs_chk u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_isr(cmd_isr),
  .cmd_wdata(cmd_wdata), .core_en(core_en), .tmr_tick(tmr_tick),
  .osc_pd(osc_pd), .pll_pd(pll_pd), .cmd_err(cmd_err)
);

// File: tb/tb_ccs_core_clk_ctrl.sv
module tb_ccs_core_clk_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] src_tick = '0;
  logic       cmd_we = 1'b0, cmd_isr = 1'b0, irq_enter = 1'b0, irq_return = 1'b0;
  logic [6:0] cmd_wdata = '0;
  logic       core_en, tmr_tick, osc_pd, pll_pd, cmd_err;

  always #2 clk = ~clk;

  ccs_core_clk_ctrl dut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .cmd_we(cmd_we), .cmd_isr(cmd_isr),
    .cmd_wdata(cmd_wdata), .irq_enter(irq_enter), .irq_return(irq_return),
    .core_en(core_en), .tmr_tick(tmr_tick), .osc_pd(osc_pd), .pll_pd(pll_pd),
    .cmd_err(cmd_err)
  );

  int checks = 0, fails = 0, ncyc = 0;
  string tag = "R1";

  // reference model state, speed words kept as integers
  int m_act = 0, m_pend = 0, m_pv = 0, m_saved = 0, m_isr = 0, m_depth = 0, m_cnt = 0;
  int m_core = 0, m_tmr = 0, m_err = 0;

  function automatic int f_src(int v); return (v >> 3) & 3; endfunction
  function automatic int f_div(int v); return v & 7; endfunction
  function automatic int f_oo(int v);  return (v >> 5) & 1; endfunction
  function automatic int f_po(int v);  return (v >> 6) & 1; endfunction
  function automatic bit legal(int v, int cur);
    if (f_src(v) == 3) return 0;
    if (f_src(v) == 0 && (f_oo(v) || f_oo(cur))) return 0;
    if (f_src(v) == 2 && (f_po(v) || f_po(cur))) return 0;
    return 1;
  endfunction

  task automatic compare();
    int exp_v, act_v;
    exp_v = (m_core << 4) | (m_tmr << 3) | (f_oo(m_act) << 2) | (f_po(m_act) << 1) | m_err;
    act_v = {27'd0, core_en, tmr_tick, osc_pd, pll_pd, cmd_err};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s cycle %0d: {core,tmr,osc_pd,pll_pd,err} actual %05b expected %05b",
               tag, ncyc, act_v[4:0], exp_v[4:0]);
    end
  endtask

  task automatic cyc(input bit we, input bit isr, input int d, input bit ent, input bit ret);
    bit t[3];
    bit sel, bnd, ok_n, ok_i, en, rt;
    int tgt, n_pend, n_pv, n_saved;
    t[0] = (ncyc % 2 == 0); t[1] = (ncyc % 9 == 0); t[2] = 1;
    src_tick = {t[2], t[1], t[0]};
    cmd_we = we; cmd_isr = isr; cmd_wdata = d[6:0]; irq_enter = ent; irq_return = ret;
    // model next state
    sel = (f_src(m_act) < 3) ? t[f_src(m_act)] : 0;
    bnd = sel && (m_cnt == (1 << f_div(m_act)) - 1);
    ok_n = we && !isr && legal(d, m_act);
    ok_i = we && isr && legal(d, 0);
    if (we && !ok_n && !ok_i) m_err = 1;
    if (ok_i) m_isr = d;
    n_saved = m_saved; n_pend = m_pend; n_pv = bnd ? 0 : m_pv;
    if (ok_n) begin
      if (m_depth > 0) n_saved = d;
      else begin n_pend = d; n_pv = 1; end
    end
    tgt = (ok_n && m_depth == 0) ? d : (m_pv ? m_pend : m_act);
    en = ent && !ret; rt = ret && !ent;
    if (en) begin
      if (m_depth == 0) begin n_saved = tgt; n_pend = m_isr; n_pv = 1; end
      if (m_depth < 7) m_depth++;
    end
    if (rt && m_depth > 0) begin
      if (m_depth == 1) begin n_pend = n_saved; n_pv = 1; end
      m_depth--;
    end
    if (bnd && m_pv) m_act = m_pend;
    m_saved = n_saved; m_pend = n_pend; m_pv = n_pv;
    m_core = bnd; m_tmr = sel;
    m_cnt = bnd ? 0 : (sel ? m_cnt + 1 : m_cnt);
    @(negedge clk);
    ncyc++;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  function automatic int word(int po, int oo, int src, int dv);
    return (po << 6) | (oo << 5) | (src << 3) | dv;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0);
    tag = "R2"; idle(10);                                        // main, div 1
    tag = "R7"; cyc(1, 0, word(0, 0, 0, 2), 0, 0); idle(30);     // main /4
    tag = "R3"; cyc(1, 0, word(0, 0, 2, 3), 0, 0); idle(40);     // pll /8
    tag = "R2"; cyc(1, 0, word(0, 0, 1, 1), 0, 0); idle(80);     // rtc /2
    tag = "R4"; cyc(1, 0, word(0, 0, 3, 0), 0, 0); idle(30);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_act = 0; m_pend = 0; m_pv = 0; m_saved = 0; m_isr = 0; m_depth = 0;
    m_cnt = 0; m_core = 0; m_tmr = 0; m_err = 0;
    tag = "R1"; compare();
    tag = "R5"; cyc(1, 0, word(0, 1, 2, 1), 0, 0); idle(20);     // pll, osc off
    tag = "R6"; cyc(1, 0, word(0, 0, 0, 0), 0, 0); idle(5);      // main while off
    tag = "R6"; cyc(1, 0, word(1, 0, 2, 0), 0, 0); idle(5);      // pll self off
    tag = "R5"; cyc(1, 0, word(1, 0, 1, 0), 0, 0); idle(40);     // rtc, pll off
    tag = "R8"; cyc(1, 1, word(0, 0, 1, 2), 0, 0); idle(20);
    tag = "R8"; cyc(1, 1, word(0, 0, 3, 2), 0, 0); idle(5);
    tag = "R9"; cyc(0, 0, 0, 1, 0); idle(60); cyc(0, 0, 0, 0, 1); idle(60);
    tag = "R10"; cyc(0, 0, 0, 1, 0); idle(20); cyc(0, 0, 0, 1, 0); idle(20);
    cyc(0, 0, 0, 0, 1); idle(40); cyc(0, 0, 0, 0, 1); idle(40); cyc(0, 0, 0, 0, 1); idle(20);
    tag = "R11"; cyc(0, 0, 0, 1, 0); idle(10); cyc(1, 0, word(0, 0, 2, 0), 0, 0);
    idle(40); cyc(0, 0, 0, 0, 1); idle(40);
    tag = "R12"; cyc(0, 0, 0, 1, 1); idle(40);
    tag = "R7";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6)       cyc(1, 0, $urandom_range(0, 127) & 8'h5f, 0, 0);
      else if (r < 8)  cyc(1, 1, $urandom_range(0, 127) & 8'h1b, 0, 0);
      else if (r < 10) cyc(0, 0, 0, 1, 0);
      else if (r < 12) cyc(0, 0, 0, 0, 1);
      else if (r < 13) cyc(1, 0, $urandom_range(0, 31) & 8'h1b, 1, 0);
      else             cyc(0, 0, 0, 0, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule